// File: doc/BRIEF.md
# Compact Load/Store Immediate Unit

This unit executes the 16-bit compressed-encoding memory instructions that address memory as a base register plus a constant. It covers word, halfword and byte transfers off a general register, and word transfers off the stack pointer. An instruction is offered with a valid strobe while the unit is idle. The unit reads the base and transfer registers through two combinational register-file read ports. It forms the address and places one request on a synchronous memory interface. For loads, it returns the zero-extended data through a register-file write port.

Addressing is pure offset: the scaled constant is added to the base, and the base is never updated. Any 16-bit encoding outside the supported opcode group is refused. The unit signals it as undefined and makes no memory access. Instructions offered while an access is in flight are ignored.

Top module: `cldst_unit`

## Requirements
- R1: Bits [15:11] select the operation, and bit 11 = 1 means load. Opcodes 01100/01101 are word (mem_size 10), 01110/01111 are byte (mem_size 00), 10000/10001 are halfword (mem_size 01), and 10010/10011 are word with a stack-pointer base. mem_we is high exactly for stores.
- R2: In the register-base forms, the base index is bits [5:3] and the transfer index is bits [2:0]. mem_addr equals base + imm5 × scale, where imm5 is bits [10:6] and scale is 4 for word, 2 for halfword and 1 for byte.
- R3: In the stack-pointer forms, the base index is 13 and the transfer index is bits [10:8]. mem_addr equals reg13 + bits[7:0] × 4.
- R4: mem_req rises in the cycle after the instruction is accepted. It stays high with an unchanged address, size, write enable and write data until a cycle with mem_ready high. That cycle ends the request.
- R5: A load writes the register file only in the one cycle in which mem_rvalid is high after its request. It writes rf_waddr = transfer index and rf_wdata = mem_rdata zero-extended to 32 bits from 8, 16 or 32 bits by size. done is high in that same cycle.
- R6: A store drives mem_wdata with the transfer register's low 8 or 16 bits zero-extended (the full word for word stores). It asserts done in its mem_ready cycle and never asserts rf_we.
- R7: An accepted instruction whose bits [15:11] lie outside 01100..10011 raises undef for exactly the next cycle and produces no mem_req.
- R8: While rst_n is low at a clock edge, the unit returns to idle. After that edge, mem_req, done, undef and rf_we are all low.
- R9: instr_valid is ignored while a request or response is pending. No second request follows the completion of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Instruction offered (taken only when idle) |
| instr | input | 16 | 16-bit instruction |
| undef | output | 1 | One-cycle pulse for an unsupported encoding |
| done | output | 1 | One-cycle pulse when the access completes |
| rf_raddr_base | output | 4 | Base register index |
| rf_rdata_base | input | 32 | Base register value |
| rf_raddr_data | output | 4 | Transfer register index |
| rf_rdata_data | input | 32 | Transfer register value |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | 00 byte, 01 halfword, 10 word |
| mem_addr | output | 32 | Effective address |
| mem_wdata | output | 32 | Store data, zero-extended |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Load data valid this cycle |
| mem_rdata | input | 32 | Load data |

## Verification
A corrupted captured instruction shows up in the first request cycle as a wrong index on a read port, a wrong size or a wrong address. A stuck or mis-sequenced controller shows up as a request that drops before mem_ready, as a second request, or as a register write outside the response cycle. Each of these is visible at the ports within one or two cycles of the fault. The bench compares every request cycle and every response cycle against values it computes from its own register-file model. It uses random waits on both handshakes.

// File: rtl/cldst_pkg.sv
// Shared types for the compact load/store unit.
// Assumes a 16-entry register file and 32-bit data/addresses.
package cldst_pkg;
    localparam int RIDX_W = 4;
    localparam int OFF_W  = 10;
    localparam logic [RIDX_W-1:0] SP_IDX = 4'd13;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } size_e;

    typedef struct packed {
        logic              load;
        size_e             size;
        logic [RIDX_W-1:0] base;
        logic [RIDX_W-1:0] rt;
        logic [OFF_W-1:0]  off;
    } op_t;
endpackage

// File: rtl/cldst_decode.sv
// Decoder: turns a 16-bit instruction into an operation descriptor.
// Purely combinational; assumes the caller samples it only when valid.
module cldst_decode
    import cldst_pkg::*;
(
    input  logic [15:0] instr,
    output logic        legal,
    output op_t         op
);
    logic [4:0] opc;
    logic [4:0] imm5;

    assign opc  = instr[15:11];
    assign imm5 = instr[10:6];

    // Classify the opcode and extract fields with per-size offset scaling.
    always_comb begin
        legal   = (opc >= 5'b01100) && (opc <= 5'b10011);
        op.load = instr[11];
        op.base = {1'b0, instr[5:3]};
        op.rt   = {1'b0, instr[2:0]};
        op.size = SZ_WORD;
        op.off  = {3'b000, imm5, 2'b00};
        case (opc[4:1])
            4'b0111: begin
                op.size = SZ_BYTE;
                op.off  = {5'b00000, imm5};
            end
            4'b1000: begin
                op.size = SZ_HALF;
                op.off  = {4'b0000, imm5, 1'b0};
            end
            4'b1001: begin
                op.base = SP_IDX;
                op.rt   = {1'b0, instr[10:8]};
                op.off  = {instr[7:0], 2'b00};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cldst_datapath.sv
// Datapath: effective address, store-data narrowing and load zero-extension.
// Combinational; assumes register values are stable while a request is held.
module cldst_datapath
    import cldst_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_t               op,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] data_val,
    input  logic [DATA_W-1:0] rd_raw,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] st_data,
    output logic [DATA_W-1:0] ld_data
);
    // Base plus scaled unsigned offset.
    assign addr = base_val + DATA_W'(op.off);

    // Narrow store data and widen load data according to access size.
    always_comb begin
        case (op.size)
            SZ_BYTE: begin
                st_data = {{(DATA_W-8){1'b0}}, data_val[7:0]};
                ld_data = {{(DATA_W-8){1'b0}}, rd_raw[7:0]};
            end
            SZ_HALF: begin
                st_data = {{(DATA_W-16){1'b0}}, data_val[15:0]};
                ld_data = {{(DATA_W-16){1'b0}}, rd_raw[15:0]};
            end
            default: begin
                st_data = data_val;
                ld_data = rd_raw;
            end
        endcase
    end
endmodule

// File: rtl/cldst_ctrl.sv
// Controller: accepts one instruction when idle, holds the memory request
// until ready, waits for load data, and pulses done/undef.
// Assumes mem_rvalid only arrives after an accepted load request.
module cldst_ctrl
    import cldst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic instr_valid,
    input  logic legal,
    input  op_t  op_in,
    input  logic mem_ready,
    input  logic mem_rvalid,
    output op_t  op_q,
    output logic mem_req,
    output logic undef,
    output logic done,
    output logic rf_we
);
    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RESP} state_e;
    state_e state;

    // Sequence idle -> request -> (response) -> idle and capture the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            undef <= 1'b0;
            op_q  <= '0;
        end else begin
            undef <= 1'b0;
            case (state)
                ST_IDLE: if (instr_valid) begin
                    if (legal) begin
                        op_q  <= op_in;
                        state <= ST_REQ;
                    end else begin
                        undef <= 1'b1;
                    end
                end
                ST_REQ: if (mem_ready) state <= op_q.load ? ST_RESP : ST_IDLE;
                ST_RESP: if (mem_rvalid) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive handshake and completion strobes from the state.
    assign mem_req = (state == ST_REQ);
    assign rf_we   = (state == ST_RESP) && mem_rvalid;
    assign done    = (mem_req && mem_ready && !op_q.load) || rf_we;

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(op_q));
    assert_undef_noreq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> !mem_req && !done);
    assert_undef_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> $past(instr_valid) && !$past(legal));
    assert_load_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> done && op_q.load && !mem_req);
    assert_store_nowe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !op_q.load |=> !rf_we);
    assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !mem_req && !rf_we);
endmodule

// File: rtl/cldst_unit.sv
// Top: compact load/store immediate unit. Connects decode, control and
// datapath; register file and memory sit outside and respond combinationally
// on the read ports.
module cldst_unit
    import cldst_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr,
    output logic              undef,
    output logic              done,
    output logic [RIDX_W-1:0] rf_raddr_base,
    input  logic [DATA_W-1:0] rf_rdata_base,
    output logic [RIDX_W-1:0] rf_raddr_data,
    input  logic [DATA_W-1:0] rf_rdata_data,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic legal;
    op_t  op_dec;
    op_t  op_q;

    cldst_decode u_dec (
        .instr (instr),
        .legal (legal),
        .op    (op_dec)
    );

    cldst_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .legal       (legal),
        .op_in       (op_dec),
        .mem_ready   (mem_ready),
        .mem_rvalid  (mem_rvalid),
        .op_q        (op_q),
        .mem_req     (mem_req),
        .undef       (undef),
        .done        (done),
        .rf_we       (rf_we)
    );

    cldst_datapath #(.DATA_W(DATA_W)) u_dp (
        .op       (op_q),
        .base_val (rf_rdata_base),
        .data_val (rf_rdata_data),
        .rd_raw   (mem_rdata),
        .addr     (mem_addr),
        .st_data  (mem_wdata),
        .ld_data  (rf_wdata)
    );

    // Register indices and request attributes come from the captured operation.
    assign rf_raddr_base = op_q.base;
    assign rf_raddr_data = op_q.rt;
    assign rf_waddr      = op_q.rt;
    assign mem_we        = !op_q.load;
    assign mem_size      = op_q.size;

    assert_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_size != 2'b11);
endmodule

// File: tb/cldst_unit_tb.sv
module cldst_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        undef, done, rf_we, mem_req, mem_we;
    logic [3:0]  rf_raddr_base, rf_raddr_data, rf_waddr;
    logic [31:0] rf_rdata_base, rf_rdata_data, rf_wdata, mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic        mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] rf [16];

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_rdata_base = rf[rf_raddr_base];
    assign rf_rdata_data = rf[rf_raddr_data];

    always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

    cldst_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .undef(undef), .done(done),
        .rf_raddr_base(rf_raddr_base), .rf_rdata_base(rf_rdata_base),
        .rf_raddr_data(rf_raddr_data), .rf_rdata_data(rf_rdata_data),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Expected model
    function automatic logic [1:0] exp_size(input logic [15:0] i);
        case (i[15:12])
            4'b0111: return 2'b00;
            4'b1000: return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic [31:0] exp_off(input logic [15:0] i);
        if (i[15:12] == 4'b1001) return {22'd0, i[7:0], 2'b00};
        case (exp_size(i))
            2'b00:   return {27'd0, i[10:6]};
            2'b01:   return {26'd0, i[10:6], 1'b0};
            default: return {25'd0, i[10:6], 2'b00};
        endcase
    endfunction

    function automatic logic [31:0] zext(input logic [1:0] sz, input logic [31:0] v);
        case (sz)
            2'b00:   return {24'd0, v[7:0]};
            2'b01:   return {16'd0, v[15:0]};
            default: return v;
        endcase
    endfunction

    task automatic run_one(input logic [15:0] ins, input int wreq, input int wrsp);
        logic [4:0]  opc;
        bit          legal, sp, ld;
        logic [3:0]  base, rt;
        logic [1:0]  sz;
        logic [31:0] ea, wd, rd;
        opc   = ins[15:11];
        legal = (opc >= 5'b01100) && (opc <= 5'b10011);
        @(negedge clk);
        instr = ins; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        #1;
        if (!legal) begin
            chk(undef == 1'b1, "R7 undef", {31'd0, undef}, 32'd1);
            chk(mem_req == 1'b0, "R7 noreq", {31'd0, mem_req}, 32'd0);
            @(negedge clk); #1;
            chk(undef == 1'b0, "R7 pulse", {31'd0, undef}, 32'd0);
            chk(mem_req == 1'b0, "R7 noreq2", {31'd0, mem_req}, 32'd0);
            return;
        end
        sp   = (ins[15:12] == 4'b1001);
        ld   = ins[11];
        base = sp ? 4'd13 : {1'b0, ins[5:3]};
        rt   = sp ? {1'b0, ins[10:8]} : {1'b0, ins[2:0]};
        sz   = exp_size(ins);
        ea   = rf[base] + exp_off(ins);
        wd   = zext(sz, rf[rt]);
        chk(undef == 1'b0, "R7 legal", {31'd0, undef}, 32'd0);
        for (int k = 0; k <= wreq; k++) begin
            if (k == wreq) mem_ready = 1'b1;
            #1;
            chk(mem_req == 1'b1, "R4 req", {31'd0, mem_req}, 32'd1);
            chk(rf_raddr_base == base, sp ? "R3 base" : "R2 base", {28'd0, rf_raddr_base}, {28'd0, base});
            chk(mem_addr == ea, sp ? "R3 addr" : "R2 addr", mem_addr, ea);
            chk(mem_size == sz, "R1 size", {30'd0, mem_size}, {30'd0, sz});
            chk(mem_we == !ld, "R1 we", {31'd0, mem_we}, {31'd0, !ld});
            if (!ld) chk(mem_wdata == wd, "R6 wdata", mem_wdata, wd);
            chk(rf_we == 1'b0, "R6 no rf_we", {31'd0, rf_we}, 32'd0);
            chk(done == (k == wreq && !ld), "R4 done", {31'd0, done}, {31'd0, (k == wreq && !ld)});
            if (k < wreq) begin
                instr = 16'h6800 | 16'($urandom_range(0, 16'h07ff));
                instr_valid = (k < wreq - 1);
            end
            @(negedge clk);
            instr_valid = 1'b0;
        end
        mem_ready = 1'b0;
        if (ld) begin
            for (int j = 0; j <= wrsp; j++) begin
                if (j == wrsp) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = $urandom;
                end
                rd = mem_rdata;
                #1;
                chk(mem_req == 1'b0, "R4 released", {31'd0, mem_req}, 32'd0);
                chk(rf_we == (j == wrsp), "R5 we", {31'd0, rf_we}, {31'd0, (j == wrsp)});
                chk(done == (j == wrsp), "R5 done", {31'd0, done}, {31'd0, (j == wrsp)});
                if (j == wrsp) begin
                    chk(rf_waddr == rt, sp ? "R3 rt" : "R2 rt", {28'd0, rf_waddr}, {28'd0, rt});
                    chk(rf_wdata == zext(sz, rd), "R5 zext", rf_wdata, zext(sz, rd));
                end
                @(negedge clk);
                mem_rvalid = 1'b0;
            end
        end else begin
            chk(rf_raddr_data == rt, sp ? "R3 rt" : "R2 rt", {28'd0, rf_raddr_data}, {28'd0, rt});
        end
        #1;
        chk(mem_req == 1'b0, "R9 no second req", {31'd0, mem_req}, 32'd0);
        chk(done == 1'b0, "R9 idle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog: actual %0d expected < 150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int r = 0; r < 16; r++) rf[r] = $urandom;
        rf[13] = 32'h2000_0000;
        repeat (3) @(negedge clk);
        #1;
        chk(mem_req == 1'b0, "R8 req", {31'd0, mem_req}, 32'd0);
        chk(done == 1'b0, "R8 done", {31'd0, done}, 32'd0);
        chk(undef == 1'b0, "R8 undef", {31'd0, undef}, 32'd0);
        chk(rf_we == 1'b0, "R8 rf_we", {31'd0, rf_we}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // Directed corners
        rf[3] = 32'hFFFF_FFFC;
        run_one(16'b01101_11111_011_001, 0, 0);   // word load, imm max, wraps
        rf[2] = 32'hA5C3_F0E1;
        run_one(16'b01110_00001_100_010, 2, 0);   // byte store, high bits dropped
        run_one(16'b01111_10101_001_110, 1, 3);   // byte load zext
        run_one(16'b10000_11111_000_010, 0, 0);   // halfword store
        run_one(16'b10001_00011_101_111, 3, 1);   // halfword load zext
        run_one(16'b10011_101_11111111, 1, 2);    // SP load, imm8 max
        run_one(16'b10010_010_00000000, 0, 0);    // SP store, zero offset
        run_one(16'b01011_00000_000_000, 0, 0);   // just below range
        run_one(16'b10100_00000_000_000, 0, 0);   // just above range
        run_one(16'hFFFF, 0, 0);
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [15:0] ins;
            ins = 16'($urandom);
            if ($urandom_range(0, 7) != 0)
                ins[15:11] = 5'(5'b01100 + $urandom_range(0, 7));
            run_one(ins, $urandom_range(0, 3), $urandom_range(0, 3));
        end
        // Reset in the middle of a request
        @(negedge clk);
        instr = 16'b01101_00000_000_000; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk); #1;
        chk(mem_req == 1'b0, "R8 mid reset", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule